// File: doc/BRIEF.md
# Programmable Clock-Enable Divider with Coarse Start Offset

This block divides a fast input clock by a programmable ratio. It produces a registered output in the same clock domain. The output alternates between a low time and a high time. Each time is set by a 4-bit field that holds the cycle count minus one. A synchronisation input clears the block and holds the output low. When that input is released, the block waits for a programmable start offset and then begins its repeating pattern.

The start offset comes from a 5-bit phase word. The word is built from a mode-select bit and a 4-bit offset field. With the select bit clear, the offset field is the delay in input clock periods. With the select bit set, the delay is the offset field plus the low-cycle count plus one. Several instances that share the sync pulse and use different offsets produce output-to-output skews in whole input clock periods.

The low-count and high-count fields are captured while sync or reset is active. They are held for the whole run.

Top module: `cdiv_phase_divider`

## Requirements
- R1: While `rst_n` is low or `sync` is high on a clock edge, `div_out` is low after that edge and all internal counts restart.
- R2: Number the rising clock edges after release as k = 0, 1, 2, and so on, where edge 0 is the first edge at which `sync` is low and `rst_n` is high. Let L = `low_cnt` + 1 and H = `high_cnt` + 1. After edge k, `div_out` is 1 exactly when k ≥ D and ((k − D) mod (L + H)) ≥ L. Otherwise it is 0.
- R3: The output period is `low_cnt` + `high_cnt` + 2 input cycles. Successive rising edges of `div_out` are exactly that many cycles apart.
- R4: When `phase_sel` = 0, the start delay is D = `phase_off`. The first rising edge of `div_out` therefore follows edge D + L.
- R5: When `phase_sel` = 1, the start delay is D = `phase_off` + `low_cnt` + 1. This is the phase word minus 16 plus the low-cycle count plus one.
- R6: `low_cnt`, `high_cnt`, `phase_off` and `phase_sel` are sampled only while `sync` or reset is active. Changes while running have no effect on `div_out`.
- R7: Two instances released by the same sync pulse have first rising edges that differ by exactly the difference of their start delays, in whole input clock periods.
- R8: Every high run of `div_out` lasts exactly H cycles, with no shorter pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Active-high synchronisation; clears and holds output low |
| low_cnt | input | 4 | Low-time cycles minus one |
| high_cnt | input | 4 | High-time cycles minus one |
| phase_off | input | 4 | Coarse start offset field |
| phase_sel | input | 1 | Phase word top bit; selects folded delay mapping |
| div_out | output | 1 | Divided output, registered |

## Verification
The assertions check four things on every cycle:
- the output is low after any sync edge;
- the output stays low while the start countdown is non-zero;
- the countdown steps by one;
- each high pulse lasts exactly the programmed high count, and the phase counter stays within the period.

Some behaviours can only be shown by the bench's scenarios. These are the exact first-edge position for all 32 phase words under several low counts, the rising-edge spacing, immunity to field changes mid-run, and the skew between two instances.

// File: rtl/cdiv_pkg.sv
// Package: shared definitions for the phase-offset divider.
// Holds the delay mapping so that all users compute it the same way.
package cdiv_pkg;

    // Meaning of the phase word's top bit.
    typedef enum logic {
        MAP_DIRECT = 1'b0,
        MAP_FOLD   = 1'b1
    } phase_map_e;

    // Start delay in input cycles for a given offset, mapping and low field.
    function automatic int unsigned calc_start_delay(
        input int unsigned offs,
        input phase_map_e  map,
        input int unsigned low_field
    );
        if (map == MAP_FOLD) begin
            return offs + low_field + 1;
        end
        return offs;
    endfunction

endpackage

// File: rtl/cdiv_cfg_latch.sv
// Module: cdiv_cfg_latch
// Captures the low/high count fields while the block is cleared and holds
// them for the run. Assumes clr is high for at least one edge before a run.
module cdiv_cfg_latch #(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               clr,
    input  logic [FIELD_W-1:0] low_in,
    input  logic [FIELD_W-1:0] high_in,
    output logic [FIELD_W-1:0] low_q,
    output logic [FIELD_W-1:0] high_q
);

    // Sample the fields only while cleared.
    always_ff @(posedge clk) begin
        if (clr) begin
            low_q  <= low_in;
            high_q <= high_in;
        end
    end

endmodule

// File: rtl/cdiv_start_delay.sv
// Module: cdiv_start_delay
// Loads the start delay while cleared and counts it down once released.
// It raises 'active' when the count reaches zero.
// Assumes the phase fields are stable on the last cleared edge.
module cdiv_start_delay #(
    parameter int FIELD_W = 4,
    localparam int CNT_W  = FIELD_W + 2
) (
    input  logic               clk,
    input  logic               clr,
    input  logic [FIELD_W-1:0] offs,
    input  logic               fold,
    input  logic [FIELD_W-1:0] low_field,
    output logic               active
);
    import cdiv_pkg::*;

    logic [CNT_W-1:0] dly_q;
    logic [CNT_W-1:0] dly_load;
    phase_map_e       map_sel;

    // Map the select bit and compute the delay to load.
    always_comb begin
        map_sel  = fold ? MAP_FOLD : MAP_DIRECT;
        dly_load = CNT_W'(calc_start_delay(int'(offs), map_sel, int'(low_field)));
    end

    // Load while cleared, count down to zero afterwards.
    always_ff @(posedge clk) begin
        if (clr) begin
            dly_q <= dly_load;
        end else if (dly_q != '0) begin
            dly_q <= dly_q - CNT_W'(1);
        end
    end

    assign active = (dly_q == '0);

    // R5: the countdown drops by exactly one per cycle until zero.
    p_countdown_r5: assert property (@(posedge clk) disable iff (clr)
        (dly_q != '0) |=> (dly_q == $past(dly_q) - CNT_W'(1)));

endmodule

// File: rtl/cdiv_period_gen.sv
// Module: cdiv_period_gen
// Once active, it steps a phase counter through one output period of
// (low+1)+(high+1) cycles. The output is low for the first low+1 steps and high
// for the rest. Assumes the count fields are held constant while running.
module cdiv_period_gen #(
    parameter int FIELD_W = 4,
    localparam int CNT_W  = FIELD_W + 2
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               active,
    input  logic [FIELD_W-1:0] low_field,
    input  logic [FIELD_W-1:0] high_field,
    output logic               out_q
);

    logic [CNT_W-1:0] ph_q;
    logic [CNT_W-1:0] lo_end;
    logic [CNT_W-1:0] last_ph;

    // Derive the low/high boundary and the last phase of the period.
    always_comb begin
        lo_end  = CNT_W'(low_field) + CNT_W'(1);
        last_ph = CNT_W'(low_field) + CNT_W'(high_field) + CNT_W'(1);
    end

    // Step the phase and register the output level.
    always_ff @(posedge clk) begin
        if (clr) begin
            ph_q  <= '0;
            out_q <= 1'b0;
        end else if (active) begin
            out_q <= (ph_q >= lo_end);
            ph_q  <= (ph_q == last_ph) ? '0 : ph_q + CNT_W'(1);
        end else begin
            out_q <= 1'b0;
        end
    end

    // Observer: length of the current high run, for the pulse-width check.
    logic [CNT_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (clr || !out_q) begin
            hi_run <= '0;
        end else begin
            hi_run <= hi_run + CNT_W'(1);
        end
    end

    // R3: the phase counter never leaves the period.
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (clr)
        ph_q <= last_ph);

    // R8: a high pulse that ends without a clear lasts exactly high+1 cycles.
    p_high_len_r8: assert property (@(posedge clk) disable iff (clr)
        ($fell(out_q) && !$past(clr)) |-> (hi_run == CNT_W'(high_field) + CNT_W'(1)));

endmodule

// File: rtl/cdiv_phase_divider.sv
// Module: cdiv_phase_divider (top)
// Clock-enable divider with a programmable low/high time and coarse start
// offset. Reset and sync both clear it.
// Assumes all fields are stable on the last edge at which sync is high.
module cdiv_phase_divider #(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync,
    input  logic [FIELD_W-1:0] low_cnt,
    input  logic [FIELD_W-1:0] high_cnt,
    input  logic [FIELD_W-1:0] phase_off,
    input  logic               phase_sel,
    output logic               div_out
);

    logic               clr;
    logic               dly_active;
    logic [FIELD_W-1:0] low_q;
    logic [FIELD_W-1:0] high_q;

    assign clr = !rst_n || sync;

    cdiv_cfg_latch #(.FIELD_W(FIELD_W)) u_cfg (
        .clk     (clk),
        .clr     (clr),
        .low_in  (low_cnt),
        .high_in (high_cnt),
        .low_q   (low_q),
        .high_q  (high_q)
    );

    cdiv_start_delay #(.FIELD_W(FIELD_W)) u_dly (
        .clk       (clk),
        .clr       (clr),
        .offs      (phase_off),
        .fold      (phase_sel),
        .low_field (low_cnt),
        .active    (dly_active)
    );

    cdiv_period_gen #(.FIELD_W(FIELD_W)) u_per (
        .clk        (clk),
        .clr        (clr),
        .active     (dly_active),
        .low_field  (low_q),
        .high_field (high_q),
        .out_q      (div_out)
    );

    // R1: a sync edge always leaves the output low.
    p_sync_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !div_out);

    // R4: no output while the start countdown is still running.
    p_delay_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dly_active && !sync) |=> !div_out);

endmodule

// File: tb/tb_cdiv_phase_divider.sv
module tb_cdiv_phase_divider;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync;
    logic [3:0] low_cnt;
    logic [3:0] high_cnt;
    logic [3:0] phase_off;
    logic       phase_sel;
    logic [3:0] phase_off_b;
    logic       div_out;
    logic       div_out_b;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdiv_phase_divider #(.FIELD_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .sync(sync),
        .low_cnt(low_cnt), .high_cnt(high_cnt),
        .phase_off(phase_off), .phase_sel(phase_sel),
        .div_out(div_out)
    );

    cdiv_phase_divider #(.FIELD_W(4)) dut_b (
        .clk(clk), .rst_n(rst_n), .sync(sync),
        .low_cnt(low_cnt), .high_cnt(high_cnt),
        .phase_off(phase_off_b), .phase_sel(1'b0),
        .div_out(div_out_b)
    );

    task automatic check(input string req, input string what, input int k,
                         input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s k=%0d actual=%0d expected=%0d", req, what, k, act, exp);
        end
    endtask

    // Behavioural reference: output level after release edge k.
    function automatic int model_level(input int k, input int d, input int m, input int n);
        int per;
        per = m + n + 2;
        if (k < d) return 0;
        return (((k - d) % per) >= m + 1) ? 1 : 0;
    endfunction

    // One run: clear with sync, release, compare every cycle.
    task automatic run_case(input int sh, input int po, input int m, input int n,
                            input int po_b, input bit scramble);
        int d_a;
        int d_b;
        int per;
        int cycles;
        int rise_a;
        int rise_b;
        int prev_rise;
        int prev_a;
        int prev_b;
        d_a = (sh != 0) ? po + m + 1 : po;
        d_b = po_b;
        per = m + n + 2;
        cycles = 35 + 2 * per;
        rise_a = -1; rise_b = -1; prev_rise = -1;
        prev_a = 0; prev_b = 0;
        sync = 1'b1;
        low_cnt = 4'(m); high_cnt = 4'(n);
        phase_off = 4'(po); phase_sel = sh[0]; phase_off_b = 4'(po_b);
        @(posedge clk);
        @(negedge clk);
        check("R1", "out during sync", -1, int'(div_out), 0);
        check("R1", "out_b during sync", -1, int'(div_out_b), 0);
        @(posedge clk);
        @(negedge clk);
        sync = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < d_a)
                check(sh != 0 ? "R5" : "R4", "delay level", k, int'(div_out), 0);
            else
                check(scramble ? "R6" : "R2", "pattern", k, int'(div_out),
                      model_level(k, d_a, m, n));
            check("R7", "second instance", k, int'(div_out_b), model_level(k, d_b, m, n));
            if (div_out && prev_a == 0) begin
                if (rise_a < 0) rise_a = k;
                if (prev_rise >= 0) check("R3", "rise spacing", k, k - prev_rise, per);
                prev_rise = k;
            end
            if (div_out_b && prev_b == 0 && rise_b < 0) rise_b = k;
            prev_a = int'(div_out);
            prev_b = int'(div_out_b);
            if (scramble && k == 20) begin
                low_cnt = ~low_cnt; high_cnt = high_cnt + 4'd7;
                phase_off = ~phase_off; phase_sel = ~phase_sel;
            end
        end
        check(sh != 0 ? "R5" : "R4", "first rise edge", po, rise_a, d_a + m + 1);
        check("R7", "skew", po_b, rise_b - rise_a, d_b - d_a);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int mset[3];
        int nset[3];
        mset[0] = 0;  mset[1] = 3; mset[2] = 15;
        nset[0] = 2;  nset[1] = 0; nset[2] = 6;
        rst_n = 1'b0; sync = 1'b0;
        low_cnt = 4'd1; high_cnt = 4'd1; phase_off = 4'd0; phase_sel = 1'b0;
        phase_off_b = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset level", -1, int'(div_out), 0);
        check("R1", "reset level b", -1, int'(div_out_b), 0);
        rst_n = 1'b1;
        // All 32 phase words under three low counts (R4, R5).
        for (int sh = 0; sh < 2; sh++)
            for (int mi = 0; mi < 3; mi++)
                for (int po = 0; po < 16; po++)
                    run_case(sh, po, mset[mi], nset[mi], (po + 5) % 16, 1'b0);
        // Field changes while running are ignored (R6).
        run_case(0, 4, 2, 3, 9, 1'b1);
        run_case(1, 7, 5, 1, 0, 1'b1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule